// File: doc/BRIEF.md
# Programmable Watchdog With Reset/Interrupt Steering

This block is a watchdog timer set up through one byte-wide configuration register. The register holds a multiplier, a power-of-four resolution and a steering bit. Together the multiplier and resolution give the timeout, counted in periods of an external 16 Hz tick. Software keeps the timer from expiring by writing the configuration register or by reading it. Either access restarts the count.

When the count runs out, the block sets a sticky bit in a flags byte that cannot be written. The steering bit then picks one of two actions:
- **Reset mode:** the block issues a one-cycle reset request, clears the configuration register to zero, and gives a one-cycle pulse that clears a neighbouring century-keeping bit.
- **Interrupt mode:** the block gives a single interrupt pulse and then stays idle until software restarts it.

The controller is a four-state machine:
- **IDLE:** not counting. The block enters IDLE from reset, after any restart whose timeout is zero, and one cycle after any expiry.
- **ARMED:** counting down ticks. A restart with a nonzero timeout moves the block to ARMED. While ARMED, each tick moves the count one step.
- **BITE_RST:** reached from ARMED when the final tick arrives and the steering bit is 1. The reset request and the century-clear pulse are high for this one cycle. The next transition is to IDLE.
- **BITE_IRQ:** reached from ARMED on the final tick when the steering bit is 0. The interrupt pulse is high for this one cycle. The next transition is to IDLE.

A restart takes priority over every other transition, in any state.

Top module: `steered_watchdog`

## Requirements
- R1: The configuration byte holds the resolution R in bits 1:0, the multiplier M in bits 6:2 and the steering bit in bit 7. The timeout is M × 4^R ticks. Expiry happens on the tick that completes that count after a restart, and never on an earlier tick.
- R2: A configuration with M = 0 (the all-zero byte included) has a zero timeout. Such a configuration leaves the timer idle: no tick ever produces an expiry.
- R3: A write stores the written byte, clears flags bit 7 and restarts the count from the new timeout.
- R4: `cfg_o` always shows the stored configuration. A read strobe clears flags bit 7 and restarts the count from the stored configuration without changing it.
- R5: Expiry sets flags bit 7. The bit stays set until the next write or read. Flags bits 6:0 always read 0.
- R6: Expiry with bit 7 = 1 gives `rst_req_o` and `century_clr_o` high for exactly one cycle, the cycle after the final tick edge. It also clears the stored configuration to 0x00.
- R7: Expiry with bit 7 = 0 gives `irq_o` high for exactly one cycle and keeps the configuration. Later ticks produce no further pulse until a restart.
- R8: After reset the configuration is 0x00, the flags are 0x00, all pulse outputs are low and the timer is idle.
- R9: `rst_req_o` and `irq_o` are never high together, and neither stays high for two consecutive cycles.
- R10: In a cycle where several events arrive together, a write wins over a read, and a restart wins over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle strobe at 16 Hz |
| wr_en_i | input | 1 | Write strobe for the configuration register |
| wr_data_i | input | 8 | Byte to write |
| rd_en_i | input | 1 | Read strobe for the configuration register (restarts the timer) |
| cfg_o | output | 8 | Stored configuration byte |
| flags_o | output | 8 | Flags byte; bit 7 is the sticky expiry flag |
| rst_req_o | output | 1 | One-cycle reset request |
| irq_o | output | 1 | One-cycle interrupt pulse |
| century_clr_o | output | 1 | One-cycle pulse that clears the neighbouring century bit |

## Verification
The assertions check several rules on every cycle:
- the reset request and the interrupt are mutually exclusive and each lasts one cycle;
- the flag is set whenever a pulse is out;
- the configuration is zero during a reset-mode bite;
- the count steps by one per tick and never sits at zero while armed;
- a write clears the flag, and a zero-multiplier write never arms the timer.

Other behaviour only the bench scenarios can show:
- that expiry lands on exactly the M × 4^R-th tick across many random configurations;
- that restarts by write and by read begin a full new period;
- that the timer stays silent after an interrupt-mode expiry;
- the priority between a write, a read and a tick arriving in the same cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_BITE_RST = 2'd2,
        ST_BITE_IRQ = 2'd3
    } wdt_state_e;

endpackage

// File: rtl/wdt_period_decode.sv
module wdt_period_decode #(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2,
    parameter int CNT_W  = MULT_W + 2 * ((1 << RES_W) - 1)
) (
    input  logic [MULT_W-1:0] mult_i,
    input  logic [RES_W-1:0]  res_i,
    output logic [CNT_W-1:0]  period_o,
    output logic              period_nz_o
);
    localparam int NUM_RES = 1 << RES_W;

    logic [CNT_W-1:0] cand [NUM_RES];

    // One scaled copy of the multiplier per resolution step (x4 each).
    for (genvar r = 0; r < NUM_RES; r++) begin : g_scale
        assign cand[r] = CNT_W'(mult_i) << (2 * r);
    end

    assign period_o    = cand[res_i];
    assign period_nz_o = |mult_i;

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (dec_i) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_W'(1));

    // R1: each accepted tick moves the count by exactly one
    a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R1: a restart starts from the full decoded period
    a_r1_load_period: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_q == $past(load_val_i)));

    // R1: no tick is ever accepted at a zero count
    a_r1_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i) |-> (cnt_q != '0));

endmodule

// File: rtl/wdt_ctrl_fsm.sv
module wdt_ctrl_fsm
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart_i,
    input  logic       period_nz_i,
    input  logic       tick_i,
    input  logic       last_i,
    input  logic       steer_rst_i,
    output wdt_state_e state_o,
    output logic       expire_o,
    output logic       dec_o,
    output logic       rst_req_o,
    output logic       irq_o,
    output logic       century_clr_o
);
    wdt_state_e state_q;
    wdt_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions; a restart overrides every state.
    always_comb begin
        state_d  = state_q;
        expire_o = 1'b0;
        if (restart_i) begin
            state_d = period_nz_i ? ST_ARMED : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ARMED: begin
                    if (tick_i && last_i) begin
                        expire_o = 1'b1;
                        state_d  = steer_rst_i ? ST_BITE_RST : ST_BITE_IRQ;
                    end
                end
                ST_BITE_RST: state_d = ST_IDLE;
                ST_BITE_IRQ: state_d = ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        rst_req_o     = 1'b0;
        irq_o         = 1'b0;
        century_clr_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ARMED: ;
            ST_BITE_RST: begin
                rst_req_o     = 1'b1;
                century_clr_o = 1'b1;
            end
            ST_BITE_IRQ: irq_o = 1'b1;
            default: ;
        endcase
    end

    assign dec_o   = tick_i && (state_q == ST_ARMED) && !restart_i;
    assign state_o = state_q;

    // R9: the two actions are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req_o && irq_o));

    // R9: the reset request lasts one cycle
    a_r9_rst_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> !rst_req_o);

    // R9: the interrupt lasts one cycle
    a_r9_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R7: after an interrupt bite the timer goes idle unless restarted
    a_r7_idle_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !restart_i) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/steered_watchdog.sv
module steered_watchdog
    import wdt_pkg::*;
#(
    parameter int MULT_W = 5,
    parameter int RES_W  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    input  logic       rd_en_i,
    output logic [7:0] cfg_o,
    output logic [7:0] flags_o,
    output logic       rst_req_o,
    output logic       irq_o,
    output logic       century_clr_o
);
    localparam int REG_W   = MULT_W + RES_W + 1;
    localparam int CNT_W   = MULT_W + 2 * ((1 << RES_W) - 1);
    localparam int STEER_B = REG_W - 1;

    logic [REG_W-1:0] cfg_q;
    logic             flag_q;
    logic [REG_W-1:0] cfg_src;
    logic             restart;
    logic [CNT_W-1:0] period;
    logic             period_nz;
    logic [CNT_W-1:0] cnt;
    logic             last;
    logic             dec;
    logic             expire;
    wdt_state_e       state;

    // A write takes the new byte; a read re-uses the stored one.
    assign restart = wr_en_i || rd_en_i;
    assign cfg_src = wr_en_i ? wr_data_i[REG_W-1:0] : cfg_q;

    wdt_period_decode #(
        .MULT_W (MULT_W),
        .RES_W  (RES_W),
        .CNT_W  (CNT_W)
    ) u_decode (
        .mult_i      (cfg_src[REG_W-2:RES_W]),
        .res_i       (cfg_src[RES_W-1:0]),
        .period_o    (period),
        .period_nz_o (period_nz)
    );

    wdt_down_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (restart),
        .load_val_i (period),
        .dec_i      (dec),
        .cnt_o      (cnt),
        .last_o     (last)
    );

    wdt_ctrl_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .restart_i     (restart),
        .period_nz_i   (period_nz),
        .tick_i        (tick_i),
        .last_i        (last),
        .steer_rst_i   (cfg_q[STEER_B]),
        .state_o       (state),
        .expire_o      (expire),
        .dec_o         (dec),
        .rst_req_o     (rst_req_o),
        .irq_o         (irq_o),
        .century_clr_o (century_clr_o)
    );

    // Configuration register: bus writes, self-clear on a reset-mode bite.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            cfg_q <= wr_data_i[REG_W-1:0];
        end else if (expire && cfg_q[STEER_B]) begin
            cfg_q <= '0;
        end
    end

    // Sticky expiry flag; only a restart clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (restart) begin
            flag_q <= 1'b0;
        end else if (expire) begin
            flag_q <= 1'b1;
        end
    end

    assign cfg_o   = 8'(cfg_q);
    assign flags_o = {flag_q, 7'b0};

    // R5: every bite pulse is accompanied by the flag
    a_r5_flag_on_bite: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_o || irq_o) |-> flag_q);

    // R6: a reset-mode bite leaves the configuration at zero
    a_r6_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |-> (cfg_q == '0));

    // R3: a write always clears the flag
    a_r3_wr_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> !flag_q);

    // R2: a zero multiplier never arms the timer
    a_r2_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_data_i[REG_W-2:RES_W] == '0)) |=> (state != ST_ARMED));

    // R2: armed state never holds a zero count
    a_r2_armed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> (cnt != '0));

endmodule

// File: tb/test_steered_watchdog.sv
module test_steered_watchdog;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = 8'h00;
    logic       rd_en_i = 1'b0;
    logic [7:0] cfg_o;
    logic [7:0] flags_o;
    logic       rst_req_o;
    logic       irq_o;
    logic       century_clr_o;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    steered_watchdog i_steered_watchdog (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick_i        (tick_i),
        .wr_en_i       (wr_en_i),
        .wr_data_i     (wr_data_i),
        .rd_en_i       (rd_en_i),
        .cfg_o         (cfg_o),
        .flags_o       (flags_o),
        .rst_req_o     (rst_req_o),
        .irq_o         (irq_o),
        .century_clr_o (century_clr_o)
    );

    function automatic int exp_period(input logic [7:0] v);
        return int'(v[6:2]) << (2 * int'(v[1:0]));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    task automatic do_write(input logic [7:0] v);
        wr_en_i = 1'b1; wr_data_i = v;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic do_read();
        rd_en_i = 1'b1;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic tick_once();
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    // Advance n ticks; return 1 if any pulse or flag appeared.
    task automatic ticks_quiet(input int n, output bit seen);
        seen = 1'b0;
        for (int k = 0; k < n; k++) begin
            tick_once();
            if (rst_req_o || irq_o || flags_o[7]) seen = 1'b1;
        end
    endtask

    task automatic check_bite(input logic [7:0] v);
        chk("R6 rst_req on bite", rst_req_o, v[7]);
        chk("R7 irq on bite", irq_o, !v[7]);
        chk("R6 century clear", century_clr_o, v[7]);
        chk("R5 flag set", flags_o, 8'h80);
        @(negedge clk);
        chk("R9 pulse single", rst_req_o | irq_o | century_clr_o, 0);
        chk("R6 R7 cfg after bite", cfg_o, v[7] ? 8'h00 : v);
    endtask

    task automatic run_case(input logic [7:0] v);
        int t;
        bit seen;
        t = exp_period(v);
        do_write(v);
        chk("R3 flag cleared by write", flags_o, 8'h00);
        if (t == 0) begin
            ticks_quiet(40, seen);
            chk("R2 zero timeout idle", seen, 0);
        end else begin
            ticks_quiet(t - 1, seen);
            chk("R1 no early expiry", seen, 0);
            tick_once();
            check_bite(v);
            seen = 1'b0;
            for (int k = 0; k < 6; k++) begin
                tick_once();
                if (rst_req_o || irq_o) seen = 1'b1;
            end
            chk("R7 silent after bite", seen, 0);
            chk("R5 flag sticky", flags_o, 8'h80);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            report();
            $finish;
        end
    end

    initial begin
        bit seen;
        logic [7:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R8: state while and after reset
        chk("R8 cfg at reset", cfg_o, 8'h00);
        chk("R8 flags at reset", flags_o, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 pulses low", {rst_req_o, irq_o, century_clr_o}, 0);
        ticks_quiet(20, seen);
        chk("R8 idle after reset", seen, 0);

        // Directed corners
        run_case(8'h04);              // M=1 R=0: one tick, interrupt
        run_case(8'h84);              // M=1 R=0: reset mode
        run_case(8'h00);              // R2 all-zero
        run_case(8'h83);              // R2 M=0 R=3
        run_case(8'h7F);              // R1 max period 1984 ticks
        run_case(8'hFE);              // R1 R=2 M=31 reset mode

        // R4: read restarts with stored value and clears flag
        run_case(8'h11);              // M=4 R=1 -> 16 ticks, irq mode, flag left set
        chk("R4 cfg readback", cfg_o, 8'h11);
        do_read();
        chk("R4 flag cleared by read", flags_o, 8'h00);
        chk("R4 cfg unchanged by read", cfg_o, 8'h11);
        ticks_quiet(10, seen);
        do_read();
        ticks_quiet(15, seen);
        chk("R4 read restart no early", seen, 0);
        tick_once();
        check_bite(8'h11);

        // R3: write mid-count restarts with the new period
        do_write(8'h0C);              // 3 ticks
        ticks_quiet(2, seen);
        do_write(8'h14);              // 5 ticks
        ticks_quiet(4, seen);
        chk("R3 write restart no early", seen, 0);
        tick_once();
        check_bite(8'h14);

        // R10: write together with tick; tick is ignored
        do_write(8'h08);              // 2 ticks
        tick_once();
        wr_en_i = 1'b1; wr_data_i = 8'h0C; tick_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; tick_i = 1'b0;
        ticks_quiet(2, seen);
        chk("R10 tick ignored on write", seen, 0);
        tick_once();
        check_bite(8'h0C);

        // R10: write and read together; write value stored
        wr_en_i = 1'b1; wr_data_i = 8'h09; rd_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; rd_en_i = 1'b0;
        chk("R10 write wins over read", cfg_o, 8'h09);
        ticks_quiet(7, seen);         // M=2 R=1 -> 8 ticks
        chk("R10 period from written value", seen, 0);
        tick_once();
        check_bite(8'h09);

        // R6: read after reset-mode bite finds zero and stays idle
        run_case(8'h88);
        do_read();
        ticks_quiet(30, seen);
        chk("R6 cleared cfg keeps idle", seen, 0);

        // Random configurations, R limited to 0..2 for run time
        for (int i = 0; i < 24; i++) begin
            v = 8'($urandom);
            if (v[1:0] == 2'd3) v[1:0] = 2'($urandom_range(0, 2));
            run_case(v);
        end

        done = 1'b1;
        report();
        $finish;
    end

endmodule